// File: doc/BRIEF.md
# I2C Slave Address and Stop Detector

This block is the bus-facing front end of an I2C target. It samples the SCL and SDA lines through synchronizers and recognises START and STOP conditions. After a START it shifts in a 7-bit address and the read/write bit, then decides whether to acknowledge. The bit is decided by either a comparison against a programmed own address, or by a promiscuous mode that takes every address. After an acknowledged address it raises an address/stop flag and stretches SCL until software clears that flag. In the write direction it then receives data bytes one at a time. Each byte is acknowledged, placed in a one-byte data register, and raises a data flag while SCL is held.

Software reaches four byte registers through a simple write/read strobe interface:
- 0 is control.
- 1 is status.
- 2 is own address.
- 3 is received data.

The block produces one interrupt request. The request is qualified by the flag enables and by a two-bit priority level, and the level travels out next to the request. The bus pins are modelled as open-drain enables: a high `*_oe_o` pulls the line low.

Top module: `i2c_slv_addr_det`

## Requirements
- R1: After reset the control, status and own-address registers read 0, `irq_o` is 0, `irq_lvl_o` is 0 and neither line is pulled low.
- R2: With slave enable set and promiscuous mode clear, an address byte whose upper 7 bits equal own-address bits 6:0 is acknowledged by pulling SDA low during the ninth clock. Any other address is not acknowledged and leaves status at 0.
- R3: With promiscuous mode set, every address is acknowledged.
- R4: After an acknowledged address, status bit 0 (address/stop flag) is 1 and status bit 2 holds the received R/W bit. SCL is held low until the flag is cleared.
- R5: In the write direction, after the address flag is cleared, each following byte is acknowledged, readable at register 3, and sets status bit 1 (data flag) while SCL is held low.
- R6: With control bit 0 (smart mode) set, reading register 3 clears the data flag and releases SCL. With it clear, the read leaves the flag set.
- R7: A STOP (SDA rising while SCL high) sets the address/stop flag when slave enable and control bit 2 (stop flag enable) are both set. It does not set the flag when bit 2 is clear.
- R8: With control bit 3 (slave enable) clear, the block pulls neither line low and sets no flag, even on its own address or a STOP.
- R9: `irq_o` is 1 exactly when control bits 7:6 (level) are nonzero and either bit 5 (data enable) with the data flag, or bit 4 (address/stop enable) with the address/stop flag, holds. `irq_lvl_o` equals the level while `irq_o` is 1 and is 0 otherwise.
- R10: Writing status with a 1 in bit 0 or bit 1 clears that flag. A 0 in a flag bit leaves that flag unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| scl_oe_o | output | 1 | Pull SCL low (clock stretch) |
| sda_oe_o | output | 1 | Pull SDA low (acknowledge) |
| reg_we_i | input | 1 | Register write strobe |
| reg_re_i | input | 1 | Register read strobe |
| reg_addr_i | input | 2 | Register select |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data (combinational) |
| irq_o | output | 1 | Interrupt request |
| irq_lvl_o | output | 2 | Level of the pending request |

## Verification
Every one of the 128 addresses is offered against a fixed own address, so a comparator off by one bit, or one that looks at the R/W bit, acknowledges a wrong address or misses the right one. Flag clearing is tested with a write of the other flag bit and with a data-register read with smart mode on and off. A block that clears on any status write, or on any read, releases SCL early and shows a zero flag. The interrupt gating is swept over all 256 control values with both flags set and then with only the data flag set. A design that ignores a zero level, or pairs an enable with the wrong flag, disagrees with the computed request. STOP handling is checked with the stop enable and the slave enable each cleared, where a wrongly ungated STOP sets the flag.

// File: rtl/i2c_sad_pkg.sv
package i2c_sad_pkg;
  localparam int REG_W = 8;

  localparam logic [1:0] REG_CTRL = 2'd0;
  localparam logic [1:0] REG_STAT = 2'd1;
  localparam logic [1:0] REG_OWN  = 2'd2;
  localparam logic [1:0] REG_DATA = 2'd3;

  // field order follows control register bits 7..0
  typedef struct packed {
    logic [1:0] lvl;
    logic       dien;
    logic       apien;
    logic       en;
    logic       pien;
    logic       promisc;
    logic       smart;
  } ctrl_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_ACK_A, ST_HOLD_A, ST_DATA, ST_ACK_D, ST_HOLD_D
  } state_e;
endpackage

// File: rtl/i2c_sad_sync.sv
module i2c_sad_sync #(
  parameter int STAGES  = 2,
  parameter bit RST_VAL = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] pipe;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pipe <= {STAGES{RST_VAL}};
    else         pipe <= {pipe[STAGES-2:0], d_i};
  end

  assign q_o = pipe[STAGES-1];
endmodule

// File: rtl/i2c_sad_cond.sv
module i2c_sad_cond (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_s_i,
  input  logic sda_s_i,
  output logic start_o,
  output logic stop_o,
  output logic rise_o,
  output logic fall_o
);
  logic scl_d, sda_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_d <= scl_s_i;
      sda_d <= sda_s_i;
    end
  end

  assign start_o = scl_s_i & scl_d & sda_d & ~sda_s_i;
  assign stop_o  = scl_s_i & scl_d & ~sda_d & sda_s_i;
  assign rise_o  = scl_s_i & ~scl_d;
  assign fall_o  = ~scl_s_i & scl_d;
endmodule

// File: rtl/i2c_sad_fsm.sv
module i2c_sad_fsm
  import i2c_sad_pkg::*;
#(
  parameter int ADDR_BITS = 7,
  localparam int FRAME    = ADDR_BITS + 1,
  localparam int CNT_W    = $clog2(FRAME + 1)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 en_i,
  input  logic                 promisc_i,
  input  logic [ADDR_BITS-1:0] own_i,
  input  logic                 start_i,
  input  logic                 stop_i,
  input  logic                 rise_i,
  input  logic                 fall_i,
  input  logic                 sda_i,
  input  logic                 apf_i,
  input  logic                 df_i,
  output logic                 set_ap_o,
  output logic                 set_d_o,
  output logic                 dir_we_o,
  output logic                 dir_o,
  output logic [FRAME-1:0]     rx_o,
  output logic                 sda_oe_o,
  output logic                 scl_oe_o
);
  state_e          state;
  logic [CNT_W-1:0] cnt;
  logic [FRAME-1:0] shreg;
  logic             dir_q;
  logic             full, hit;

  assign full = (cnt == CNT_W'(FRAME));
  assign hit  = promisc_i || (shreg[FRAME-1:1] == own_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state <= ST_IDLE;
      cnt   <= '0;
      shreg <= '0;
      dir_q <= 1'b0;
    end else if (!en_i) begin
      state <= ST_IDLE;
    end else if (start_i) begin
      state <= ST_ADDR;
      cnt   <= '0;
    end else if (stop_i) begin
      state <= ST_IDLE;
    end else begin
      unique case (state)
        ST_ADDR, ST_DATA: begin
          if (rise_i && !full) begin
            shreg <= {shreg[FRAME-2:0], sda_i};
            cnt   <= cnt + 1'b1;
          end else if (fall_i && full) begin
            if (state == ST_DATA) state <= ST_ACK_D;
            else if (hit) begin
              state <= ST_ACK_A;
              dir_q <= shreg[0];
            end else state <= ST_IDLE;
          end
        end
        ST_ACK_A: if (fall_i) state <= ST_HOLD_A;
        ST_ACK_D: if (fall_i) state <= ST_HOLD_D;
        ST_HOLD_A: if (!apf_i) begin
          state <= dir_q ? ST_IDLE : ST_DATA;
          cnt   <= '0;
        end
        ST_HOLD_D: if (!df_i) begin
          state <= ST_DATA;
          cnt   <= '0;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // flag pulses on the ACK clock falling edge
  assign set_ap_o = en_i && !start_i && !stop_i && state == ST_ACK_A && fall_i;
  assign set_d_o  = en_i && !start_i && !stop_i && state == ST_ACK_D && fall_i;
  assign dir_we_o = set_ap_o;
  assign dir_o    = dir_q;
  assign rx_o     = shreg;

  assign sda_oe_o = en_i && (state == ST_ACK_A || state == ST_ACK_D);
  assign scl_oe_o = en_i && ((state == ST_HOLD_A && apf_i) ||
                             (state == ST_HOLD_D && df_i));
endmodule

// File: rtl/i2c_sad_regs.sv
module i2c_sad_regs
  import i2c_sad_pkg::*;
#(
  parameter int ADDR_BITS = 7,
  localparam int FRAME    = ADDR_BITS + 1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 we_i,
  input  logic                 re_i,
  input  logic [1:0]           addr_i,
  input  logic [REG_W-1:0]     wdata_i,
  output logic [REG_W-1:0]     rdata_o,
  input  logic                 set_ap_i,
  input  logic                 set_d_i,
  input  logic                 stop_i,
  input  logic                 dir_we_i,
  input  logic                 dir_i,
  input  logic [FRAME-1:0]     rx_i,
  output ctrl_t                ctrl_o,
  output logic [ADDR_BITS-1:0] own_o,
  output logic                 apf_o,
  output logic                 df_o,
  output logic                 irq_o,
  output logic [1:0]           irq_lvl_o
);
  ctrl_t                ctrl_q;
  logic [ADDR_BITS-1:0] own_q;
  logic                 apf_q, df_q, dir_q;
  logic [FRAME-1:0]     data_q;
  logic                 set_ap, clr_ap, clr_d;

  assign set_ap = set_ap_i || (stop_i && ctrl_q.en && ctrl_q.pien);
  assign clr_ap = we_i && addr_i == REG_STAT && wdata_i[0];
  assign clr_d  = (we_i && addr_i == REG_STAT && wdata_i[1]) ||
                  (re_i && addr_i == REG_DATA && ctrl_q.smart);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      own_q  <= '0;
      apf_q  <= 1'b0;
      df_q   <= 1'b0;
      dir_q  <= 1'b0;
      data_q <= '0;
    end else begin
      if (we_i && addr_i == REG_CTRL) ctrl_q <= ctrl_t'(wdata_i);
      if (we_i && addr_i == REG_OWN)  own_q  <= wdata_i[ADDR_BITS-1:0];
      // set wins over a clear in the same cycle
      if (set_ap)      apf_q <= 1'b1;
      else if (clr_ap) apf_q <= 1'b0;
      if (set_d_i)     df_q  <= 1'b1;
      else if (clr_d)  df_q  <= 1'b0;
      if (dir_we_i)    dir_q <= dir_i;
      if (set_d_i)     data_q <= rx_i;
    end
  end

  always_comb begin
    unique case (addr_i)
      REG_CTRL: rdata_o = ctrl_q;
      REG_STAT: rdata_o = {5'b0, dir_q, df_q, apf_q};
      REG_OWN:  rdata_o = REG_W'(own_q);
      default:  rdata_o = REG_W'(data_q);
    endcase
  end

  assign irq_o     = (ctrl_q.lvl != 2'b00) &&
                     ((ctrl_q.dien && df_q) || (ctrl_q.apien && apf_q));
  assign irq_lvl_o = irq_o ? ctrl_q.lvl : 2'b00;
  assign ctrl_o    = ctrl_q;
  assign own_o     = own_q;
  assign apf_o     = apf_q;
  assign df_o      = df_q;
endmodule

// File: rtl/i2c_slv_addr_det.sv
module i2c_slv_addr_det
  import i2c_sad_pkg::*;
#(
  parameter int ADDR_BITS   = 7,
  parameter int SYNC_STAGES = 2,
  localparam int FRAME      = ADDR_BITS + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             scl_i,
  input  logic             sda_i,
  output logic             scl_oe_o,
  output logic             sda_oe_o,
  input  logic             reg_we_i,
  input  logic             reg_re_i,
  input  logic [1:0]       reg_addr_i,
  input  logic [REG_W-1:0] reg_wdata_i,
  output logic [REG_W-1:0] reg_rdata_o,
  output logic             irq_o,
  output logic [1:0]       irq_lvl_o
);
  logic                 scl_s, sda_s;
  logic                 start_w, stop_w, rise_w, fall_w;
  logic                 set_ap_w, set_d_w, dir_we_w, dir_w;
  logic [FRAME-1:0]     rx_w;
  ctrl_t                ctrl_w;
  logic [ADDR_BITS-1:0] own_w;
  logic                 apf_w, df_w;

  i2c_sad_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_scl (
    .clk_i, .rst_ni, .d_i(scl_i), .q_o(scl_s));
  i2c_sad_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_sda (
    .clk_i, .rst_ni, .d_i(sda_i), .q_o(sda_s));

  i2c_sad_cond u_cond (
    .clk_i, .rst_ni, .scl_s_i(scl_s), .sda_s_i(sda_s),
    .start_o(start_w), .stop_o(stop_w), .rise_o(rise_w), .fall_o(fall_w));

  i2c_sad_fsm #(.ADDR_BITS(ADDR_BITS)) u_fsm (
    .clk_i, .rst_ni,
    .en_i(ctrl_w.en), .promisc_i(ctrl_w.promisc), .own_i(own_w),
    .start_i(start_w), .stop_i(stop_w), .rise_i(rise_w), .fall_i(fall_w),
    .sda_i(sda_s), .apf_i(apf_w), .df_i(df_w),
    .set_ap_o(set_ap_w), .set_d_o(set_d_w), .dir_we_o(dir_we_w), .dir_o(dir_w),
    .rx_o(rx_w), .sda_oe_o(sda_oe_o), .scl_oe_o(scl_oe_o));

  i2c_sad_regs #(.ADDR_BITS(ADDR_BITS)) u_regs (
    .clk_i, .rst_ni,
    .we_i(reg_we_i), .re_i(reg_re_i), .addr_i(reg_addr_i),
    .wdata_i(reg_wdata_i), .rdata_o(reg_rdata_o),
    .set_ap_i(set_ap_w), .set_d_i(set_d_w), .stop_i(stop_w),
    .dir_we_i(dir_we_w), .dir_i(dir_w), .rx_i(rx_w),
    .ctrl_o(ctrl_w), .own_o(own_w), .apf_o(apf_w), .df_o(df_w),
    .irq_o(irq_o), .irq_lvl_o(irq_lvl_o));
endmodule

// File: rtl/i2c_sad_chk.sv
module i2c_sad_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [7:0] ctrl,
  input logic       apf,
  input logic       df,
  input logic       stop,
  input logic       irq_o,
  input logic       sda_oe_o,
  input logic       scl_oe_o
);
  logic [1:0] lvl;
  logic dien, apien, en, pien;
  assign lvl   = ctrl[7:6];
  assign dien  = ctrl[5];
  assign apien = ctrl[4];
  assign en    = ctrl[3];
  assign pien  = ctrl[2];

  assert_irq_needs_level_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> lvl != 2'b00);
  assert_irq_on_data_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lvl != 2'b00 && dien && df) |-> irq_o);
  assert_quiet_when_off_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en |-> (!sda_oe_o && !scl_oe_o));
  assert_hold_needs_flag_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    scl_oe_o |-> (apf || df));
  assert_stop_sets_flag_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stop && en && pien) |=> apf);
  assert_ack_not_during_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(sda_oe_o && scl_oe_o));
endmodule

bind i2c_slv_addr_det i2c_sad_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .ctrl(ctrl_w), .apf(apf_w), .df(df_w),
  .stop(stop_w), .irq_o(irq_o), .sda_oe_o(sda_oe_o), .scl_oe_o(scl_oe_o));

// File: tb/test_i2c_slv_addr_det.sv
module test_i2c_slv_addr_det;
  localparam int CLK_PERIOD = 10;
  localparam int Q = 8;
  localparam logic [6:0] OWN = 7'h5A;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       scl_m = 1'b1, sda_m = 1'b1;
  logic       scl_oe, sda_oe;
  logic       we = 1'b0, re = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wdata = 8'd0;
  logic [7:0] rdata;
  logic       irq;
  logic [1:0] irq_lvl;
  wire        scl_bus = scl_m & ~scl_oe;
  wire        sda_bus = sda_m & ~sda_oe;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  i2c_slv_addr_det i_i2c_slv_addr_det (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl_bus), .sda_i(sda_bus),
    .scl_oe_o(scl_oe), .sda_oe_o(sda_oe),
    .reg_we_i(we), .reg_re_i(re), .reg_addr_i(addr), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .irq_o(irq), .irq_lvl_o(irq_lvl));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic reg_wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic reg_rd(input logic [1:0] a, input bit strobe, output logic [7:0] d);
    @(negedge clk);
    addr = a; re = strobe;
    #1 d = rdata;
    @(negedge clk);
    re = 1'b0;
  endtask

  task automatic scl_high();
    scl_m = 1'b1;
    @(negedge clk);
    while (!scl_bus) @(negedge clk);
  endtask

  task automatic m_start();
    sda_m = 1'b1; scl_m = 1'b1; wt(Q);
    sda_m = 1'b0; wt(Q);
    scl_m = 1'b0; wt(Q);
  endtask

  task automatic m_stop();
    sda_m = 1'b0; wt(Q);
    scl_high(); wt(Q);
    sda_m = 1'b1; wt(Q);
  endtask

  task automatic m_byte(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; wt(Q);
      scl_high(); wt(Q);
      scl_m = 1'b0; wt(Q);
    end
    sda_m = 1'b1; wt(Q);
    scl_high(); wt(Q / 2);
    ack = !sda_bus;
    wt(Q / 2);
    scl_m = 1'b0; wt(Q);
  endtask

  initial begin
    repeat (180000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual %0d expected %0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] rd;
    bit ack;
    wt(3);
    // R1 reset state
    chk(irq == 1'b0 && irq_lvl == 2'b00, "R1 irq", {irq, irq_lvl}, 0);
    chk(!scl_oe && !sda_oe, "R1 bus", {scl_oe, sda_oe}, 0);
    rst_n = 1'b1;
    wt(2);
    reg_rd(2'd0, 1'b0, rd); chk(rd == 8'h00, "R1 ctrl", rd, 0);
    reg_rd(2'd1, 1'b0, rd); chk(rd == 8'h00, "R1 status", rd, 0);
    reg_rd(2'd2, 1'b0, rd); chk(rd == 8'h00, "R1 own", rd, 0);

    // R2 / R4 / R10 sweep of every address, read direction
    reg_wr(2'd2, {1'b0, OWN});
    reg_wr(2'd0, 8'h08);
    for (int a = 0; a < 128; a++) begin
      m_start();
      m_byte({a[6:0], 1'b1}, ack);
      chk(ack == (a == OWN), "R2 ack", ack, a == OWN);
      wt(4);
      if (a == OWN) begin
        chk(scl_oe == 1'b1, "R4 stretch", scl_oe, 1);
        reg_rd(2'd1, 1'b0, rd);
        chk(rd == 8'h05, "R4 status", rd, 8'h05);
        reg_wr(2'd1, 8'h02);
        reg_rd(2'd1, 1'b0, rd);
        chk(rd[0] == 1'b1, "R10 zero bit kept", rd[0], 1);
        reg_wr(2'd1, 8'h01);
        wt(2);
        chk(scl_oe == 1'b0, "R4 release", scl_oe, 0);
        reg_rd(2'd1, 1'b0, rd);
        chk(rd[0] == 1'b0, "R10 cleared", rd[0], 0);
      end else begin
        reg_rd(2'd1, 1'b0, rd);
        chk(rd[1:0] == 2'b00, "R2 no flag", rd, 0);
      end
      m_stop();
    end

    // R3 promiscuous
    reg_wr(2'd0, 8'h0A);
    for (int k = 0; k < 4; k++) begin
      logic [6:0] pa;
      pa = 7'(k * 37 + 1);
      m_start();
      m_byte({pa, 1'b1}, ack);
      chk(ack == 1'b1, "R3 ack", ack, 1);
      wt(4);
      reg_wr(2'd1, 8'h01);
      m_stop();
    end

    // R5 / R6 write direction data
    reg_wr(2'd0, 8'h08);
    m_start();
    m_byte({OWN, 1'b0}, ack);
    chk(ack == 1'b1, "R2 write ack", ack, 1);
    wt(4);
    reg_rd(2'd1, 1'b0, rd);
    chk(rd == 8'h01, "R4 dir write", rd, 8'h01);
    reg_wr(2'd1, 8'h01);
    m_byte(8'hC3, ack);
    chk(ack == 1'b1, "R5 data ack", ack, 1);
    wt(4);
    chk(scl_oe == 1'b1, "R5 stretch", scl_oe, 1);
    reg_rd(2'd3, 1'b1, rd);
    chk(rd == 8'hC3, "R5 data", rd, 8'hC3);
    reg_rd(2'd1, 1'b0, rd);
    chk(rd[1] == 1'b1, "R6 no smart keeps flag", rd, 8'h02);
    reg_wr(2'd1, 8'h02);
    wt(2);
    chk(scl_oe == 1'b0, "R10 data clear", scl_oe, 0);
    reg_wr(2'd0, 8'h09);
    m_byte(8'h3C, ack);
    chk(ack == 1'b1, "R5 second ack", ack, 1);
    wt(4);
    reg_rd(2'd3, 1'b1, rd);
    chk(rd == 8'h3C, "R5 second data", rd, 8'h3C);
    wt(2);
    reg_rd(2'd1, 1'b0, rd);
    chk(rd[1] == 1'b0, "R6 smart read clears", rd, 0);
    chk(scl_oe == 1'b0, "R6 release", scl_oe, 0);
    m_stop();

    // R7 stop flag
    reg_wr(2'd0, 8'h08);
    m_start(); m_byte(8'h10, ack); m_stop();
    reg_rd(2'd1, 1'b0, rd);
    chk(rd[0] == 1'b0, "R7 stop ignored", rd, 0);
    reg_wr(2'd0, 8'h0C);
    m_start(); m_byte(8'h10, ack); m_stop();
    reg_rd(2'd1, 1'b0, rd);
    chk(rd[0] == 1'b1, "R7 stop flag", rd, 1);
    reg_wr(2'd1, 8'h01);

    // R8 disabled
    reg_wr(2'd0, 8'h04);
    m_start();
    m_byte({OWN, 1'b1}, ack);
    chk(ack == 1'b0, "R8 no ack", ack, 0);
    wt(4);
    chk(scl_oe == 1'b0, "R8 no stretch", scl_oe, 0);
    m_stop();
    reg_rd(2'd1, 1'b0, rd);
    chk(rd[1:0] == 2'b00, "R8 no flag", rd, 0);

    // R9 interrupt gating sweeps
    reg_wr(2'd0, 8'h08);
    m_start(); m_byte({OWN, 1'b0}, ack); wt(4);
    reg_wr(2'd1, 8'h01);
    m_byte(8'h55, ack); wt(4);
    reg_wr(2'd0, 8'h04);
    reg_wr(2'd0, 8'h0C);
    m_stop();
    reg_rd(2'd1, 1'b0, rd);
    chk(rd[1:0] == 2'b11, "R9 setup flags", rd, 3);
    for (int pass = 0; pass < 2; pass++) begin
      for (int c = 0; c < 256; c++) begin
        bit exp_irq;
        reg_wr(2'd0, 8'(c));
        exp_irq = (c[7:6] != 0) && (c[5] || (pass == 0 && c[4]));
        chk(irq == exp_irq && irq_lvl == (exp_irq ? 2'(c[7:6]) : 2'b00),
            "R9 irq", {irq, irq_lvl}, {exp_irq, exp_irq ? 2'(c[7:6]) : 2'b00});
      end
      reg_wr(2'd1, 8'h01);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule